// File: doc/BRIEF.md
# Flash Program Memory Control Register

This block is the 8-bit control register that software uses to launch self-timed erase and write cycles on an on-chip program memory. A CPU-side port writes the register (`reg_we` with `wr_data`) and reads it back through `rd_data`. The block drives a one-cycle start strobe toward the memory array, one for writes and one for row erases. It also drives a select line that steers the operation to configuration space or to program space, and a busy line that stays high for the whole cycle. The cycle length comes from an internal down-counter, with separate lengths for writes and erases.

The start bit can be raised by software but only lowered by hardware. An error flag records cycles that a reset cut short, and attempts to start a cycle while writing is disabled. Power-on reset (`por_n`, asynchronous, active low) clears everything. The separate warm reset (`warm_rst`, synchronous, active high) leaves the space select untouched, so software can see which space a failed cycle was aimed at.

The sequencer has three states. `ST_IDLE` goes to `ST_PROG` on an accepted start with row-erase enable at 0. It goes to `ST_ERASE` on an accepted start with row-erase enable at 1. Either busy state returns to `ST_IDLE` in two cases: when the counter expires (normal completion), or when a warm reset arrives (abort).

Top module: `nvm_ctl_reg`

## Requirements
- R1: After power-on reset, `rd_data` is 0x00, and `busy`, `prog_go`, `erase_go` and `cfg_sel` are 0.
- R2: `rd_data` maps the register as bit 6 space select, bit 4 row-erase enable, bit 3 error flag, bit 2 write enable and bit 1 start. Bits 7, 5 and 0 always read 0. An idle write loads bits 6, 4 and 2 from `wr_data`, and `cfg_sel` equals bit 6.
- R3: An idle write with `wr_data[1]`=1, `wr_data[2]`=1 and `wr_data[4]`=0 starts a write cycle. `busy` and the start bit are 1 for exactly PROG_CYCLES cycles, beginning the cycle after the write. `prog_go` is high in the first of those cycles only.
- R4: An idle write with `wr_data[1]`=1, `wr_data[2]`=1 and `wr_data[4]`=1 starts an erase. `busy` lasts ERASE_CYCLES cycles, `erase_go` pulses in the first cycle, and row-erase enable reads 0 once the erase completes.
- R5: Normal completion clears the start bit and the error flag.
- R6: An idle write with `wr_data[1]`=1 and `wr_data[2]`=0 is improper. No cycle starts, no strobe fires, the start bit stays 0 and the error flag becomes 1.
- R7: Writing 0 to the start bit has no effect. During a cycle it does not end the cycle, and while idle it starts nothing.
- R8: While busy, writes do not change space select (`cfg_sel`, bit 6) or row-erase enable (bit 4). Write enable (bit 2) stays writable.
- R9: Software clears the error flag by writing 0 to bit 3. Writing 1 to bit 3 never sets it.
- R10: A warm reset during a cycle aborts it. On the next cycle `busy` is 0, the error flag is 1, bits 1, 2 and 4 are 0, and space select is unchanged.
- R11: A warm reset while idle clears write enable and row-erase enable, and keeps space select and the error flag.
- R12: `prog_go` and `erase_go` are never high together, and each is high only while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| warm_rst | input | 1 | Non-power-on reset, synchronous, active high |
| reg_we | input | 1 | Register write strobe from the CPU |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read value |
| prog_go | output | 1 | One-cycle start-write strobe to the array |
| erase_go | output | 1 | One-cycle start-row-erase strobe to the array |
| cfg_sel | output | 1 | 1 = configuration space, 0 = program space |
| busy | output | 1 | High for the whole self-timed cycle |

## Verification
A wrong sequencer state or counter value shows on `busy` and on the start bit in `rd_data` one cycle after the start write. An off-by-one length shows at the very last cycle of the operation, as a too-early or too-late fall of `busy`. Mishandled flag state is visible in the same cycle's read-back. Examples are an error flag not set by an abort, row-erase enable not cleared after an erase, or a select bit overwritten during a cycle. A reference model steps alongside the design, and every output is compared after every clock edge, so any divergence is reported in the cycle it first appears.

// File: rtl/nvm_ctl_pkg.sv
package nvm_ctl_pkg;
    localparam int REG_W     = 8;
    localparam int B_SEL     = 6;
    localparam int B_ERASE   = 4;
    localparam int B_ERR     = 3;
    localparam int B_WEN     = 2;
    localparam int B_START   = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_ERASE = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/nvm_cycle_timer.sv
module nvm_cycle_timer #(
    parameter int PROG_CYCLES  = 16,
    parameter int ERASE_CYCLES = 32
) (
    input  logic clk,
    input  logic por_n,
    input  logic load,
    input  logic erase_sel,
    input  logic run,
    output logic done
);
    localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] PROG_LAST  = CW'(PROG_CYCLES - 1);
    localparam logic [CW-1:0] ERASE_LAST = CW'(ERASE_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= erase_sel ? ERASE_LAST : PROG_LAST;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = run && (cnt_q == '0);
endmodule

// File: rtl/nvm_ctl_fsm.sv
module nvm_ctl_fsm
    import nvm_ctl_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic abort,
    input  logic go,
    input  logic erase_req,
    input  logic done,
    output logic busy,
    output logic prog_go,
    output logic erase_go,
    output logic load,
    output logic fin_erase,
    output logic fin_any
);
    ctl_state_e state_q, state_d;
    logic       fresh_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) state_d = erase_req ? ST_ERASE : ST_PROG;
            end
            ST_PROG, ST_ERASE: begin
                if (abort || done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_IDLE;
            fresh_q <= 1'b0;
        end else begin
            state_q <= state_d;
            fresh_q <= (state_q == ST_IDLE) && (state_d != ST_IDLE);
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        prog_go   = (state_q == ST_PROG) && fresh_q;
        erase_go  = (state_q == ST_ERASE) && fresh_q;
        load      = (state_q == ST_IDLE) && go;
        fin_any   = busy && done && !abort;
        fin_erase = (state_q == ST_ERASE) && done && !abort;
    end
endmodule

// File: rtl/nvm_ctl_reg.sv
module nvm_ctl_reg
    import nvm_ctl_pkg::*;
#(
    parameter int PROG_CYCLES  = 16,
    parameter int ERASE_CYCLES = 32
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             warm_rst,
    input  logic             reg_we,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             prog_go,
    output logic             erase_go,
    output logic             cfg_sel,
    output logic             busy
);
    logic sel_q, erase_q, err_q, wen_q;
    logic go, load, done, fin_erase, fin_any;
    logic unused_bits;

    assign unused_bits = ^{wr_data[7], wr_data[5], wr_data[0]};

    // proper start: idle, start bit and enable written together
    assign go = reg_we && !busy && !warm_rst && wr_data[B_START] && wr_data[B_WEN];

    nvm_ctl_fsm u_fsm (
        .clk       (clk),
        .por_n     (por_n),
        .abort     (warm_rst),
        .go        (go),
        .erase_req (wr_data[B_ERASE]),
        .done      (done),
        .busy      (busy),
        .prog_go   (prog_go),
        .erase_go  (erase_go),
        .load      (load),
        .fin_erase (fin_erase),
        .fin_any   (fin_any)
    );

    nvm_cycle_timer #(
        .PROG_CYCLES  (PROG_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_timer (
        .clk       (clk),
        .por_n     (por_n),
        .load      (load),
        .erase_sel (wr_data[B_ERASE]),
        .run       (busy),
        .done      (done)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sel_q   <= 1'b0;
            erase_q <= 1'b0;
            err_q   <= 1'b0;
            wen_q   <= 1'b0;
        end else if (warm_rst) begin
            wen_q   <= 1'b0;
            erase_q <= 1'b0;
            if (busy) err_q <= 1'b1;
        end else begin
            if (fin_any)   err_q   <= 1'b0;
            if (fin_erase) erase_q <= 1'b0;
            if (reg_we) begin
                wen_q <= wr_data[B_WEN];
                if (!busy) begin
                    sel_q   <= wr_data[B_SEL];
                    erase_q <= wr_data[B_ERASE];
                end
                if (!busy && wr_data[B_START] && !wr_data[B_WEN]) begin
                    err_q <= 1'b1;
                end else if (!wr_data[B_ERR]) begin
                    err_q <= 1'b0;
                end
            end
        end
    end

    assign cfg_sel = sel_q;
    assign rd_data = {1'b0, sel_q, 1'b0, erase_q, err_q, wen_q, busy, 1'b0};
endmodule

// File: rtl/nvm_ctl_reg_chk.sv
module nvm_ctl_reg_chk (
    input logic clk,
    input logic por_n,
    input logic warm_rst,
    input logic reg_we,
    input logic wd_start,
    input logic wd_wen,
    input logic wd_err,
    input logic rd_erase,
    input logic rd_err,
    input logic rd_wen,
    input logic rd_start,
    input logic prog_go,
    input logic erase_go,
    input logic cfg_sel,
    input logic busy
);
    a_r12_one_strobe: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({prog_go, erase_go}));

    a_r12_strobe_in_busy: assert property (@(posedge clk) disable iff (!por_n)
        (prog_go || erase_go) |-> busy);

    a_r3_go_starts: assert property (@(posedge clk) disable iff (!por_n)
        (reg_we && !busy && !warm_rst && wd_start && wd_wen) |=> (busy && rd_start && (prog_go || erase_go)));

    a_r6_improper: assert property (@(posedge clk) disable iff (!por_n)
        (reg_we && !busy && !warm_rst && wd_start && !wd_wen) |=> (!busy && !rd_start && rd_err && !prog_go && !erase_go));

    a_r10_abort: assert property (@(posedge clk) disable iff (!por_n)
        (warm_rst && busy) |=> (!busy && rd_err && !rd_wen && !rd_erase && $stable(cfg_sel)));

    a_r8_sel_held: assert property (@(posedge clk) disable iff (!por_n)
        busy |=> $stable(cfg_sel));

    a_r5_done_clears_err: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(busy) && !$past(warm_rst)) |-> !rd_err);

    a_r9_no_sw_set: assert property (@(posedge clk) disable iff (!por_n)
        (reg_we && wd_err && !rd_err && !warm_rst && (busy || !wd_start || wd_wen)) |=> !rd_err);
endmodule

bind nvm_ctl_reg nvm_ctl_reg_chk u_chk (
    .clk      (clk),
    .por_n    (por_n),
    .warm_rst (warm_rst),
    .reg_we   (reg_we),
    .wd_start (wr_data[1]),
    .wd_wen   (wr_data[2]),
    .wd_err   (wr_data[3]),
    .rd_erase (rd_data[4]),
    .rd_err   (rd_data[3]),
    .rd_wen   (rd_data[2]),
    .rd_start (rd_data[1]),
    .prog_go  (prog_go),
    .erase_go (erase_go),
    .cfg_sel  (cfg_sel),
    .busy     (busy)
);

// File: tb/test_nvm_ctl_reg.sv
`timescale 1ns/1ps
module test_nvm_ctl_reg;
    localparam int PC = 16;
    localparam int EC = 32;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       warm_rst = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       prog_go, erase_go, cfg_sel, busy;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    string phase = "R1";

    // reference model state
    logic m_sel = 0, m_erase = 0, m_err = 0, m_wen = 0, m_busy = 0, m_kind = 0, m_fresh = 0;
    int   m_left = 0;

    always #4 clk = ~clk;

    nvm_ctl_reg #(.PROG_CYCLES(PC), .ERASE_CYCLES(EC)) i_nvm_ctl_reg (
        .clk(clk), .por_n(por_n), .warm_rst(warm_rst), .reg_we(reg_we),
        .wr_data(wr_data), .rd_data(rd_data), .prog_go(prog_go),
        .erase_go(erase_go), .cfg_sel(cfg_sel), .busy(busy)
    );

    function automatic logic [7:0] exp_rd();
        return {1'b0, m_sel, 1'b0, m_erase, m_err, m_wen, m_busy, 1'b0};
    endfunction

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL [%s] %s %s act=%02h exp=%02h at %0t", phase, req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2", "rd_data", rd_data, exp_rd());
        chk("R3", "busy", {7'd0, busy}, {7'd0, m_busy});
        chk("R12", "prog_go", {7'd0, prog_go}, {7'd0, m_busy && m_fresh && !m_kind});
        chk("R12", "erase_go", {7'd0, erase_go}, {7'd0, m_busy && m_fresh && m_kind});
        chk("R8", "cfg_sel", {7'd0, cfg_sel}, {7'd0, m_sel});
    endtask

    task automatic model_step(input logic we, input logic [7:0] d, input logic wr);
        logic was_busy;
        was_busy = m_busy;
        if (wr) begin
            if (m_busy) m_err = 1'b1;
            m_busy = 0; m_fresh = 0; m_wen = 0; m_erase = 0;
        end else begin
            if (m_busy) begin
                m_fresh = 0;
                if (m_left == 1) begin
                    m_busy = 0; m_err = 0;
                    if (m_kind) m_erase = 0;
                end else begin
                    m_left--;
                end
            end
            if (we) begin
                m_wen = d[2];
                if (!was_busy) begin
                    m_sel = d[6];
                    m_erase = d[4];
                    if (d[1] && d[2]) begin
                        m_busy = 1; m_kind = d[4]; m_fresh = 1;
                        m_left = d[4] ? EC : PC;
                    end
                end
                if (!was_busy && d[1] && !d[2]) m_err = 1'b1;
                else if (!d[3]) m_err = 1'b0;
            end
        end
    endtask

    // one clock: drive at negedge, update model at posedge, compare at next negedge
    task automatic cyc(input logic we, input logic [7:0] d, input logic wr);
        reg_we = we; wr_data = d; warm_rst = wr;
        @(posedge clk);
        model_step(we, d, wr);
        @(negedge clk);
        reg_we = 1'b0; warm_rst = 1'b0;
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        phase = "R1";
        chk("R1", "reset rd_data", rd_data, 8'h00);
        chk("R1", "reset outputs", {4'd0, busy, prog_go, erase_go, cfg_sel}, 8'h00);

        phase = "R2";
        cyc(1'b1, 8'h54, 1'b0);
        chk("R2", "layout after 0x54", rd_data, 8'h54);
        cyc(1'b1, 8'hA9, 1'b0);
        chk("R2", "unused bits read 0", rd_data, 8'h00);

        phase = "R3";
        cyc(1'b1, 8'h04, 1'b0);
        cyc(1'b1, 8'h06, 1'b0);
        chk("R3", "prog_go first cycle", {7'd0, prog_go}, 8'h01);
        idle(PC + 2);

        phase = "R4";
        cyc(1'b1, 8'h16, 1'b0);
        chk("R4", "erase_go first cycle", {7'd0, erase_go}, 8'h01);
        idle(EC + 2);
        chk("R4", "erase enable cleared", {7'd0, rd_data[4]}, 8'h00);

        phase = "R6";
        cyc(1'b1, 8'h02, 1'b0);
        chk("R6", "improper sets err", rd_data, 8'h08);
        idle(3);

        phase = "R5";
        cyc(1'b1, 8'h0E, 1'b0);
        idle(PC + 1);
        chk("R5", "completion clears err/start", rd_data & 8'h0A, 8'h00);

        phase = "R7";
        cyc(1'b1, 8'h06, 1'b0);
        idle(3);
        cyc(1'b1, 8'h04, 1'b0);
        chk("R7", "start 0 keeps busy", {7'd0, busy}, 8'h01);

        phase = "R8";
        cyc(1'b1, 8'h50, 1'b0);
        chk("R8", "sel/erase held busy", {cfg_sel, rd_data[4], 6'd0}, 8'h00);
        idle(PC);

        phase = "R9";
        cyc(1'b1, 8'h02, 1'b0);
        cyc(1'b1, 8'h08, 1'b0);
        chk("R9", "write 1 keeps err", {7'd0, rd_data[3]}, 8'h01);
        cyc(1'b1, 8'h00, 1'b0);
        chk("R9", "write 0 clears err", {7'd0, rd_data[3]}, 8'h00);
        cyc(1'b1, 8'h08, 1'b0);
        chk("R9", "write 1 does not set", {7'd0, rd_data[3]}, 8'h00);

        phase = "R10";
        cyc(1'b1, 8'h46, 1'b0);
        idle(5);
        cyc(1'b0, 8'h00, 1'b1);
        chk("R10", "abort", rd_data, 8'h48);
        chk("R10", "abort busy", {7'd0, busy}, 8'h00);
        idle(2);

        phase = "R11";
        cyc(1'b1, 8'h54, 1'b0);
        cyc(1'b1, 8'h02, 1'b0);
        cyc(1'b1, 8'h5C, 1'b0);
        cyc(1'b0, 8'h00, 1'b1);
        chk("R11", "idle warm reset", rd_data, 8'h48);

        phase = "R3 random";
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 4000; i++) begin
            logic we, wr;
            logic [7:0] d;
            we = ($urandom % 4) == 0;
            wr = ($urandom % 80) == 0;
            d  = 8'($urandom);
            if (($urandom % 3) == 0) d[2] = 1'b1;
            cyc(we, d, wr);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL [watchdog] R3 run did not end act=0 exp=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule